// File: doc/BRIEF.md
# Speech Frame Pre-emphasis Energy Detector

This block takes a stream of signed 16-bit audio samples arriving at 8 kHz, each one marked by a valid strobe. It first sharpens the high end of the spectrum by subtracting 0.95 times the previous sample from the current one. It then measures short-time energy over analysis windows of 160 filtered samples, which is 20 ms. Successive windows start 80 samples apart, so each window overlaps the one before it by half. The weighting across a window is flat.

Each window energy is presented on a 40-bit output together with a one-cycle done strobe. The energy is also compared against an upper and a lower threshold, both supplied by the surrounding logic. A run of loud windows raises a word-start pulse. A later run of quiet windows raises a word-end pulse. Because the two thresholds are separate and the two runs have different lengths, the decision has hysteresis.

The window sum is built from two half-window accumulators. As a result, no sample history is stored inside the block.

Top module: `speech_energy_vad`

## Requirements
- R1: Each accepted sample X is filtered as y = X - r, where r = (31130·P + 16384) >>> 15 and P is the previously accepted sample. The result y is saturated to the range -32768..32767. For example, P = -32768 followed by X = 32767 gives y = 32767.
- R2: After reset, the previous-sample register holds zero. As a result, eight samples of 1000 produce a first window energy of 1000² + 7·50² = 1017500.
- R3: `frame_energy` equals the sum of y² over the most recent 160 filtered samples (2·HOP in general). It is an unsigned 40-bit value.
- R4: `frame_done` is a one-cycle pulse. It fires in the cycle after the clock edge that accepts sample number 160, and then again after every further 80 samples. `frame_energy` changes only when `frame_done` fires.
- R5: While the block is idle, `speech_start` pulses once the energy has been strictly above `thr_hi` in 3 consecutive windows. Any window not above `thr_hi` clears that run.
- R6: While a word is active, `speech_end` pulses once the energy has been strictly below `thr_lo` in 5 consecutive windows. Any window not below `thr_lo` clears that run.
- R7: `speech_start` and `speech_end` only ever fire together with `frame_done`. Start and end pulses alternate, and start comes first after reset.
- R8: While reset is held, and in the first cycle after it, `frame_done`, `frame_energy`, `speech_start` and `speech_end` are all zero.
- R9: The value on `in_sample` has no effect in any cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_sample` |
| in_sample | input | DW | Signed audio sample |
| thr_hi | input | ACC_W | Word-start energy threshold |
| thr_lo | input | ACC_W | Word-end energy threshold |
| frame_done | output | 1 | One-cycle strobe: a new window energy is valid |
| frame_energy | output | ACC_W | Energy of the latest window |
| speech_start | output | 1 | Word-start pulse |
| speech_end | output | 1 | Word-end pulse |

## Verification
The bench builds the block with HOP = 4, which gives an eight-sample window, and keeps the default run lengths of 3 and 5. Short windows bring a lot within reach in a few hundred cycles. They include the first-window latency, the half-overlap cadence, start and end decisions, a broken run that must not start a word, and a medium-level stretch that clears both runs. They also reach full-scale alternating input, which drives the filter into saturation at both rails. The default 40-bit accumulator is kept, so the energy arithmetic is checked at its real width.

// File: rtl/speech_energy_vad.sv
module speech_energy_vad #(
  parameter int DW        = 16,
  parameter int HOP       = 80,
  parameter int COEF      = 31130,
  parameter int ACC_W     = 40,
  parameter int START_RUN = 3,
  parameter int END_RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_sample,
  input  logic [ACC_W-1:0] thr_hi,
  input  logic [ACC_W-1:0] thr_lo,
  output logic             frame_done,
  output logic [ACC_W-1:0] frame_energy,
  output logic             speech_start,
  output logic             speech_end
);
  localparam int PW = 2*DW + 2;
  localparam int CW = (HOP > 1) ? $clog2(HOP) : 1;
  localparam int RW = $clog2(START_RUN + END_RUN + 1);
  localparam logic signed [DW+1:0] SAT_HI = (DW+2)'(2**(DW-1) - 1);
  localparam logic signed [DW+1:0] SAT_LO = -(DW+2)'(2**(DW-1));

  logic signed [DW-1:0]   prev_q;
  logic [CW-1:0]          cnt;
  logic                   primed, talking;
  logic [ACC_W-1:0]       half_acc, prev_half;
  logic [RW-1:0]          hi_run, lo_run;

  logic signed [PW-1:0]   prod, rnd;
  logic signed [DW+1:0]   diff;
  logic signed [DW-1:0]   filt;
  logic signed [2*DW-1:0] fw, sqw;
  logic [ACC_W-1:0]       sq, sum_now, new_e;
  logic                   last, above, below;

  always_comb begin
    prod = PW'(COEF) * PW'(prev_q);
    rnd  = (prod + (PW'(1) <<< (DW-2))) >>> (DW-1);
    diff = (DW+2)'($signed(in_sample)) - (DW+2)'(rnd);
    if (diff > SAT_HI)      filt = SAT_HI[DW-1:0];
    else if (diff < SAT_LO) filt = SAT_LO[DW-1:0];
    else                    filt = diff[DW-1:0];
    fw      = (2*DW)'(filt);
    sqw     = fw * fw;
    sq      = ACC_W'($unsigned(sqw));
    sum_now = half_acc + sq;
    new_e   = prev_half + sum_now;
  end

  assign last  = (cnt == CW'(HOP-1));
  assign above = new_e > thr_hi;
  assign below = new_e < thr_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q       <= '0;
      cnt          <= '0;
      primed       <= 1'b0;
      talking      <= 1'b0;
      half_acc     <= '0;
      prev_half    <= '0;
      hi_run       <= '0;
      lo_run       <= '0;
      frame_done   <= 1'b0;
      frame_energy <= '0;
      speech_start <= 1'b0;
      speech_end   <= 1'b0;
    end else begin
      frame_done   <= 1'b0;
      speech_start <= 1'b0;
      speech_end   <= 1'b0;
      if (in_valid) begin
        prev_q <= $signed(in_sample);
        if (!last) begin
          cnt      <= cnt + 1'b1;
          half_acc <= sum_now;
        end else begin
          cnt       <= '0;
          half_acc  <= '0;
          prev_half <= sum_now;
          primed    <= 1'b1;
          if (primed) begin
            frame_done   <= 1'b1;
            frame_energy <= new_e;
            if (!talking) begin
              lo_run <= '0;
              if (!above) hi_run <= '0;
              else if (hi_run == RW'(START_RUN-1)) begin
                hi_run       <= '0;
                talking      <= 1'b1;
                speech_start <= 1'b1;
              end else hi_run <= hi_run + 1'b1;
            end else begin
              hi_run <= '0;
              if (!below) lo_run <= '0;
              else if (lo_run == RW'(END_RUN-1)) begin
                lo_run     <= '0;
                talking    <= 1'b0;
                speech_end <= 1'b1;
              end else lo_run <= lo_run + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/speech_energy_vad_chk.sv
module speech_energy_vad_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             frame_done,
  input logic [ACC_W-1:0] frame_energy,
  input logic             speech_start,
  input logic             speech_end
);
  logic in_word;
  always_ff @(posedge clk) begin
    if (!rst_n) in_word <= 1'b0;
    else if (speech_start) in_word <= 1'b1;
    else if (speech_end) in_word <= 1'b0;
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r4_done_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(in_valid));
  a_r4_energy_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_energy) |-> frame_done);
  a_r7_start_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    speech_start |-> frame_done);
  a_r7_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    speech_end |-> frame_done);
  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    speech_start |-> !in_word);
  a_r7_end_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    speech_end |-> in_word);
endmodule

bind speech_energy_vad speech_energy_vad_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_done(frame_done),
  .frame_energy(frame_energy), .speech_start(speech_start), .speech_end(speech_end)
);

// File: tb/speech_energy_vad_bench.sv
module speech_energy_vad_bench;
  localparam int HOP = 4, FR = 2*HOP, SR = 3, ER = 5, AW = 40;
  localparam int NSEG = 10;
  // {amplitude[15:0], count[7:0], mode[7:0]} ; mode 0 constant, 1 +/-amp, 2 amp / -amp-1
  localparam logic [31:0] SEG [NSEG] = '{
    {16'd0,     8'd16, 8'd0},
    {16'd8000,  8'd12, 8'd1},
    {16'd20,    8'd32, 8'd0},
    {16'd8000,  8'd8,  8'd1},
    {16'd20,    8'd8,  8'd0},
    {16'd32767, 8'd16, 8'd2},
    {16'd3000,  8'd24, 8'd1},
    {16'd5,     8'd40, 8'd0},
    {16'd12000, 8'd16, 8'd1},
    {16'd0,     8'd48, 8'd0}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [15:0] in_sample = '0;
  logic [AW-1:0] thr_hi = 40'd1000000000, thr_lo = 40'd2000000;
  logic frame_done, speech_start, speech_end;
  logic [AW-1:0] frame_energy;

  int checks = 0, fails = 0, starts = 0, ends = 0;
  longint hist [FR];
  longint m_prev = 0, m_n = 0;
  int m_hi = 0, m_lo = 0;
  bit m_talk = 0;

  always #2 clk = ~clk;

  speech_energy_vad #(.HOP(HOP), .START_RUN(SR), .END_RUN(ER)) u_speech_energy_vad (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .frame_done(frame_done),
    .frame_energy(frame_energy), .speech_start(speech_start), .speech_end(speech_end));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint pre(input longint x, input longint p);
    longint r, d;
    r = (31130 * p + 16384) >>> 15;
    d = x - r;
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  task automatic model_reset();
    m_prev = 0; m_n = 0; m_hi = 0; m_lo = 0; m_talk = 0;
    for (int i = 0; i < FR; i++) hist[i] = 0;
  endtask

  task automatic send(input logic signed [15:0] x);
    longint y, e;
    bit exp_done, exp_s, exp_e;
    @(negedge clk);
    in_valid = 1; in_sample = x;
    y = pre(longint'(x), m_prev);
    m_prev = longint'(x);
    for (int i = FR-1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = y;
    m_n++;
    exp_done = (m_n >= FR) && (m_n % HOP == 0);
    e = 0;
    for (int i = 0; i < FR; i++) e += hist[i] * hist[i];
    exp_s = 0; exp_e = 0;
    if (exp_done) begin
      if (!m_talk) begin
        m_lo = 0;
        if (e > longint'(thr_hi)) begin
          m_hi++;
          if (m_hi == SR) begin m_hi = 0; m_talk = 1; exp_s = 1; end
        end else m_hi = 0;
      end else begin
        m_hi = 0;
        if (e < longint'(thr_lo)) begin
          m_lo++;
          if (m_lo == ER) begin m_lo = 0; m_talk = 0; exp_e = 1; end
        end else m_lo = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sample = ~x;  // junk while invalid (R9)
    chk(frame_done == exp_done, "R4 frame_done", frame_done, exp_done);
    if (exp_done) chk(frame_energy == AW'(e), "R3 frame_energy", longint'(frame_energy), e);
    chk(speech_start == exp_s, "R5 speech_start", speech_start, exp_s);
    chk(speech_end == exp_e, "R6 speech_end", speech_end, exp_e);
    if (speech_start) starts++;
    if (speech_end) ends++;
    repeat (2) @(negedge clk);
    chk(frame_done == 0, "R4 pulse width", frame_done, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(frame_done == 0 && speech_start == 0 && speech_end == 0, "R8 strobes in reset",
        {frame_done, speech_start, speech_end}, 0);
    chk(frame_energy == 0, "R8 energy in reset", longint'(frame_energy), 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk(frame_energy == 0 && frame_done == 0, "R8 after release", longint'(frame_energy), 0);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // table walk: R1, R3, R4, R5, R6
    for (int s = 0; s < NSEG; s++) begin
      logic signed [15:0] amp;
      amp = SEG[s][31:16];
      for (int k = 0; k < int'(SEG[s][15:8]); k++) begin
        if (SEG[s][7:0] == 8'd0) send(amp);
        else if (SEG[s][7:0] == 8'd1) send(k[0] ? -amp : amp);
        else send(k[0] ? (-amp - 16'sd1) : amp);
      end
      // R9: idle cycles with noisy sample and valid low
      repeat (5) begin @(negedge clk); in_sample = 16'h7A5C ^ in_sample; end
    end
    chk(starts >= 2, "R7 starts seen", starts, 2);
    chk(ends >= 2, "R7 ends seen", ends, 2);

    // R2: previous sample cleared by reset
    do_reset();
    for (int k = 0; k < FR - 1; k++) send(16'sd1000);
    @(negedge clk); in_valid = 1; in_sample = 16'sd1000;
    @(negedge clk); in_valid = 0;
    chk(frame_done == 1 && frame_energy == 40'd1017500, "R2 first window", longint'(frame_energy), 1017500);

    // R1: saturation at both rails, observed through an 8-sample window
    do_reset();
    send(-16'sd32768);
    send(16'sd32767);      // y = +32767 (sat)
    send(-16'sd32768);     // y = -32768 (sat)
    for (int k = 0; k < 5; k++) send(16'sd0);
    chk(1, "R1 sat window issued", 0, 0);
    send(16'sd0); send(16'sd0); send(16'sd0); send(16'sd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule